// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block drives the active-low supply enable of an LCD panel and the drive state of the panel interface signals. It orders the two so that the panel is never powered while its interface is idle and carrying DC levels. Powering up always enables the interface drivers first and then switches the supply on. Powering down always switches the supply off first and then idles the interface.

A power-down starts on any of three conditions: a suspend request, either of the two sequencer-run bits going to 0, or loss of the display-timing-running status. Power-up needs all four conditions: no suspend, both run bits at 1, and timing running. Each step holds for a fixed settle time, set by a parameter, before the next step begins. A sequence that has started always runs to its end before a request in the other direction is acted on. A strap is captured when reset is released. It chooses how the idle interface looks: all signals driven low, or all signals in high impedance.

States: `PS_OFF` (supply off, interface idle), `PS_IF_ACTIVE_WAIT` (interface driving, supply still off), `PS_POWER_ON` (supply on, settling), `PS_RUNNING`, `PS_POWER_OFF_WAIT` (supply off, interface still driving) and `PS_IF_INACTIVE` (interface idle, settling). Transitions: OFF to IF_ACTIVE_WAIT when power-up is wanted. IF_ACTIVE_WAIT to POWER_ON after IF_SETTLE_CYCLES. POWER_ON to RUNNING after PWR_SETTLE_CYCLES. RUNNING to POWER_OFF_WAIT when power-up is no longer wanted. POWER_OFF_WAIT to IF_INACTIVE after PWR_SETTLE_CYCLES. IF_INACTIVE to OFF after IF_SETTLE_CYCLES.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is asserted and after it is released, panel_pwr_n is 1 and the interface is idle, until a power-up sequence starts.
- R2: With the block in OFF and power-up wanted at a clock edge, the interface becomes active (if_oe=1, if_force_low=0) after that edge. panel_pwr_n stays 1 for IF_SETTLE_CYCLES cycles, then goes to 0 and stays 0.
- R3: In RUNNING, a suspend request seen at an edge drives panel_pwr_n to 1 after that edge. The interface stays active for PWR_SETTLE_CYCLES cycles and then goes idle. The block reaches OFF IF_SETTLE_CYCLES cycles after that.
- R4: In RUNNING, seq_run_a=0, seq_run_b=0 or timing_running=0 each start the same power-down sequence as R3, with the same timing.
- R5: In OFF, with timing running, no power-up starts unless both run bits are 1 and suspend_req is 0.
- R6: In OFF, no power-up starts while timing_running is 0, whatever the other inputs are.
- R7: An idle interface is in high impedance (if_oe=0, if_force_low=0) when the latched strap is 1. It is driven low (if_oe=1, if_force_low=1) when the latched strap is 0.
- R8: The strap is captured at the first clock edge after reset is released. Later changes on strap_tristate have no effect until the next reset.
- R9: A power-down request that arrives during a power-up sequence does not shorten it. panel_pwr_n goes low on schedule, the block reaches RUNNING, and power-down starts at the following edge.
- R10: A power-up request that arrives during a power-down sequence does not shorten it. The block completes IF_INACTIVE and reaches OFF, and the interface becomes active again at the next edge.
- R11: panel_pwr_n is never 0 while the interface is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_req | input | 1 | Suspend request, 1 = enter suspend |
| seq_run_a | input | 1 | First sequencer-run bit |
| seq_run_b | input | 1 | Second sequencer-run bit |
| timing_running | input | 1 | Display timing generator programmed and running |
| strap_tristate | input | 1 | Idle-state strap: 1 = high impedance, 0 = drive low |
| panel_pwr_n | output | 1 | Panel supply enable, active low |
| if_oe | output | 1 | Interface output enable |
| if_force_low | output | 1 | Force all interface signals low |

## Verification
The bench builds the block with IF_SETTLE_CYCLES=3 and PWR_SETTLE_CYCLES=5. These short settle times make every cycle of a full sequence cheap to step through and count exactly. For both strap values, it sweeps all sixteen input combinations from OFF and all four power-down triggers from RUNNING. It also injects a power-down request at every cycle offset of a power-up sequence. Each expected edge time is computed from the two settle parameters.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

    typedef enum logic [2:0] {
        PS_OFF            = 3'd0,
        PS_IF_ACTIVE_WAIT = 3'd1,
        PS_POWER_ON       = 3'd2,
        PS_RUNNING        = 3'd3,
        PS_POWER_OFF_WAIT = 3'd4,
        PS_IF_INACTIVE    = 3'd5
    } pps_state_e;

endpackage

// File: rtl/pps_strap_latch.sv
`timescale 1ns/1ps
// Captures the idle-state strap on the first edge after reset release.
module pps_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic tri_mode
);
    logic armed_q;
    logic strap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            strap_q <= 1'b0;
        end else if (armed_q) begin
            armed_q <= 1'b0;
            strap_q <= strap_in;
        end
    end

    // Until capture the pin itself selects the idle state.
    assign tri_mode = armed_q ? strap_in : strap_q;
endmodule

// File: rtl/pps_wait_timer.sv
`timescale 1ns/1ps
// Down counter: loaded on state entry, done when it reaches zero.
module pps_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pps_fsm.sv
`timescale 1ns/1ps
module pps_fsm
    import pps_pkg::*;
#(
    parameter int IF_SETTLE_CYCLES  = 16,
    parameter int PWR_SETTLE_CYCLES = 64,
    parameter int W                 = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         want_up,
    input  logic         timer_done,
    output logic         timer_load,
    output logic [W-1:0] timer_val,
    output logic         panel_on,
    output logic         drive_active
);
    localparam logic [W-1:0] IF_LOAD  = W'(IF_SETTLE_CYCLES - 1);
    localparam logic [W-1:0] PWR_LOAD = W'(PWR_SETTLE_CYCLES - 1);

    pps_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a started sequence always runs to its end.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:            if (want_up)    state_d = PS_IF_ACTIVE_WAIT;
            PS_IF_ACTIVE_WAIT: if (timer_done) state_d = PS_POWER_ON;
            PS_POWER_ON:       if (timer_done) state_d = PS_RUNNING;
            PS_RUNNING:        if (!want_up)   state_d = PS_POWER_OFF_WAIT;
            PS_POWER_OFF_WAIT: if (timer_done) state_d = PS_IF_INACTIVE;
            PS_IF_INACTIVE:    if (timer_done) state_d = PS_OFF;
            default:                           state_d = PS_OFF;
        endcase
    end

    // Settle timer is reloaded on every state change.
    always_comb begin
        timer_load = (state_d != state_q);
        timer_val  = ((state_d == PS_IF_ACTIVE_WAIT) || (state_d == PS_IF_INACTIVE))
                     ? IF_LOAD : PWR_LOAD;
    end

    // Outputs
    always_comb begin
        panel_on     = 1'b0;
        drive_active = 1'b0;
        unique case (state_q)
            PS_OFF:            begin panel_on = 1'b0; drive_active = 1'b0; end
            PS_IF_ACTIVE_WAIT: begin panel_on = 1'b0; drive_active = 1'b1; end
            PS_POWER_ON:       begin panel_on = 1'b1; drive_active = 1'b1; end
            PS_RUNNING:        begin panel_on = 1'b1; drive_active = 1'b1; end
            PS_POWER_OFF_WAIT: begin panel_on = 1'b0; drive_active = 1'b1; end
            PS_IF_INACTIVE:    begin panel_on = 1'b0; drive_active = 1'b0; end
            default:           begin panel_on = 1'b0; drive_active = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lcd_pwr_seq.sv
`timescale 1ns/1ps
module lcd_pwr_seq #(
    parameter int IF_SETTLE_CYCLES  = 16,
    parameter int PWR_SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic suspend_req,
    input  logic seq_run_a,
    input  logic seq_run_b,
    input  logic timing_running,
    input  logic strap_tristate,
    output logic panel_pwr_n,
    output logic if_oe,
    output logic if_force_low
);
    localparam int MAX_SETTLE = (IF_SETTLE_CYCLES > PWR_SETTLE_CYCLES)
                                ? IF_SETTLE_CYCLES : PWR_SETTLE_CYCLES;
    localparam int TW = (MAX_SETTLE > 1) ? $clog2(MAX_SETTLE) : 1;

    logic          want_up;
    logic          timer_load;
    logic [TW-1:0] timer_val;
    logic          timer_done;
    logic          panel_on;
    logic          drive_active;
    logic          tri_mode;

    assign want_up = !suspend_req && seq_run_a && seq_run_b && timing_running;

    pps_strap_latch u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_tristate),
        .tri_mode (tri_mode)
    );

    pps_wait_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    pps_fsm #(
        .IF_SETTLE_CYCLES  (IF_SETTLE_CYCLES),
        .PWR_SETTLE_CYCLES (PWR_SETTLE_CYCLES),
        .W                 (TW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .want_up      (want_up),
        .timer_done   (timer_done),
        .timer_load   (timer_load),
        .timer_val    (timer_val),
        .panel_on     (panel_on),
        .drive_active (drive_active)
    );

    assign panel_pwr_n  = !panel_on;
    assign if_oe        = drive_active || !tri_mode;
    assign if_force_low = !drive_active && !tri_mode;
endmodule

// File: rtl/pps_checker.sv
`timescale 1ns/1ps
module pps_checker (
    input logic clk,
    input logic rst_n,
    input logic suspend_req,
    input logic seq_run_a,
    input logic seq_run_b,
    input logic timing_running,
    input logic panel_pwr_n,
    input logic if_oe,
    input logic if_force_low
);
    logic if_active;
    logic want;
    assign if_active = if_oe && !if_force_low;
    assign want      = !suspend_req && seq_run_a && seq_run_b && timing_running;

    assert_pwr_needs_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_pwr_n |-> if_active);

    assert_drive_before_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_pwr_n) |-> $past(if_active));

    assert_off_before_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(if_active) |-> $past(panel_pwr_n));

    assert_idle_keeps_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !if_active |=> panel_pwr_n);

    assert_idle_encoding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !if_active |-> (if_force_low == if_oe));

    assert_up_needs_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_active) |-> $past(want));
endmodule

bind lcd_pwr_seq pps_checker u_pps_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .suspend_req    (suspend_req),
    .seq_run_a      (seq_run_a),
    .seq_run_b      (seq_run_b),
    .timing_running (timing_running),
    .panel_pwr_n    (panel_pwr_n),
    .if_oe          (if_oe),
    .if_force_low   (if_force_low)
);

// File: tb/tb_lcd_pwr_seq.sv
`timescale 1ns/1ps
module tb_lcd_pwr_seq;
    localparam int IFS = 3;
    localparam int PWS = 5;
    // {panel_pwr_n, if_oe, if_force_low}
    localparam logic [2:0] E_RUN = 3'b010;
    localparam logic [2:0] E_ACT = 3'b110;
    localparam logic [2:0] E_TRI = 3'b100;
    localparam logic [2:0] E_LOW = 3'b111;
    // {suspend, run_a, run_b, timing}
    localparam logic [3:0] WANT = 4'b0111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic suspend_req = 1'b0, seq_run_a = 1'b0, seq_run_b = 1'b0, timing_running = 1'b0;
    logic strap_tristate = 1'b0;
    logic panel_pwr_n, if_oe, if_force_low;
    logic strap_l;
    int   nchk = 0;
    int   nbad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    lcd_pwr_seq #(.IF_SETTLE_CYCLES(IFS), .PWR_SETTLE_CYCLES(PWS)) dut (
        .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
        .seq_run_a(seq_run_a), .seq_run_b(seq_run_b),
        .timing_running(timing_running), .strap_tristate(strap_tristate),
        .panel_pwr_n(panel_pwr_n), .if_oe(if_oe), .if_force_low(if_force_low)
    );

    function automatic logic [2:0] idle_exp();
        return strap_l ? E_TRI : E_LOW;
    endfunction

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {panel_pwr_n, if_oe, if_force_low};
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input logic [3:0] v);
        {suspend_req, seq_run_a, seq_run_b, timing_running} = v;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        strap_tristate = s;
        strap_l = s;
        set_in(4'b0000);
        adv(2);
        chk("R1", idle_exp());
        chk("R7", idle_exp());
        rst_n = 1'b1;
        adv(1);
        chk("R1", idle_exp());
        strap_tristate = ~s;   // later strap changes must be ignored (R8)
        adv(3);
        chk("R8", idle_exp());
    endtask

    // Caller applied WANT at the current negedge, block in OFF.
    task automatic up_from_off(input string tag);
        adv(1);       chk(tag, E_ACT);
        adv(IFS - 1); chk(tag, E_ACT);
        adv(1);       chk(tag, E_RUN);
        adv(PWS);     chk(tag, E_RUN);
    endtask

    // From RUNNING; restore: 0 never, 1 after first edge, 2 once idle.
    task automatic down_from_run(input string tag, input logic [3:0] trig, input int restore);
        set_in(trig);
        adv(1);       chk(tag, E_ACT);
        if (restore == 1) set_in(WANT);
        adv(PWS - 1); chk(tag, E_ACT);
        adv(1);       chk(tag, idle_exp());
        if (restore == 2) set_in(WANT);
        adv(IFS);     chk(restore != 0 ? "R10" : tag, idle_exp());
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            // Sweep every input combination from OFF
            for (int c = 0; c < 16; c++) begin
                if (c[3:0] != WANT) begin
                    set_in(c[3:0]);
                    adv(IFS + PWS + 2);
                    chk(c[0] ? "R5" : "R6", idle_exp());
                end
            end
            set_in(WANT);
            up_from_off("R2");
            // Each power-down trigger, then restart during the down sequence
            for (int d = 0; d < 4; d++) begin
                logic [3:0] trig;
                trig = (d == 0) ? 4'b1111 : (d == 1) ? 4'b0011 :
                       (d == 2) ? 4'b0101 : 4'b0110;
                down_from_run(d == 0 ? "R3" : "R4", trig, (d % 2 == 0) ? 2 : 1);
                up_from_off("R10");
            end
            down_from_run("R4", 4'b0011, 0);
            // Power-down request at every offset of a power-up sequence
            for (int j = 1; j <= IFS + PWS; j++) begin
                set_in(WANT);
                adv(j);
                set_in(4'b1111);
                adv(IFS + PWS + 1 - j); chk("R9", E_RUN);
                adv(1);                 chk("R9", E_ACT);
                adv(PWS);               chk("R9", idle_exp());
                adv(IFS);               chk("R9", idle_exp());
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule